// File: doc/BRIEF.md
# Processor Debug Event Collector

This block sits beside a processor pipeline and turns per-cycle pipeline conditions into debug events. Each cycle it receives strobes for a taken branch, an instruction that completed, a completed normal or critical interrupt return, an interrupt that was taken, a trap instruction together with its condition, instruction-address and data-address match results from comparators outside the block, and an unconditional request that may come from the test access port or from external logic. Each event class has its own enable bit. An enabled event drives the single debug event output in the same cycle and sets a sticky status bit on the next clock edge.

Every event class has a fixed timing. Taken branch, trap, instruction-address match and data-address match are raised before the instruction executes, so the block asserts a hold signal that stops that instruction in the same cycle. Completion, interrupt return, interrupt taken and unconditional events are raised after the fact and never hold the pipeline. Software programs the enable register and clears status bits through a small write port. The status vector is visible as an output.

Top module: `dbg_event_collector`

## Requirements
- R1: After synchronous reset all enable bits and all status bits are 0, and `dbg_event` and `hold_instr` are low.
- R2: A write with `cfg_addr` = 0 loads `cfg_wdata` into the enable register from the next clock edge. Bit order for enables, status and clear is: 0 taken branch, 1 completion, 2 interrupt return, 3 interrupt taken, 4 trap, 5 instruction-address match, 6 data-address match, 7 unconditional.
- R3: An event whose enable bit is 0 sets no status bit and drives neither `dbg_event` nor `hold_instr`.
- R4: An enabled event drives `dbg_event` high combinationally in the cycle its strobe is present.
- R5: Enabled pre-execution events (bits 0, 4, 5, 6) drive `hold_instr` high in the same cycle.
- R6: Post-completion events (bits 1, 2, 3, 7) never drive `hold_instr`.
- R7: An enabled event sets its status bit on the next clock edge. The bit stays set until it is cleared.
- R8: A write with `cfg_addr` = 1 clears each status bit whose `cfg_wdata` bit is 1 and leaves the others unchanged. If the same bit is cleared and hit in the same cycle, the bit stays set.
- R9: Several enabled events in one cycle all set their status bits on the same clock edge.
- R10: The unconditional event (bit 7) fires on `tap_req`, on `ext_req`, or on both.
- R11: The trap event (bit 4) fires only when `trap_instr` and `trap_cond` are both high.
- R12: The interrupt return event (bit 2) fires on either `norm_ret_done` or `crit_ret_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the enable register, 1 selects the status clear |
| cfg_wdata | input | 8 | Write data |
| br_taken | input | 1 | Taken branch about to execute |
| instr_done | input | 1 | An instruction completed |
| norm_ret_done | input | 1 | Normal interrupt return completed |
| crit_ret_done | input | 1 | Critical interrupt return completed |
| irq_taken | input | 1 | An interrupt was taken |
| trap_instr | input | 1 | A trap instruction is about to execute |
| trap_cond | input | 1 | The trap condition is true |
| iaddr_match | input | 1 | Instruction-address comparator hit |
| daddr_match | input | 1 | Data-address comparator hit |
| tap_req | input | 1 | Unconditional request from the test access port |
| ext_req | input | 1 | Unconditional request from external logic |
| dbg_event | output | 1 | Debug event raised this cycle |
| hold_instr | output | 1 | Hold the current instruction (pre-execution event) |
| status | output | 8 | Sticky event status |

## Verification
Some properties hold on every cycle, and assertions check those. A hold never appears without a debug event. A post-completion-only cycle never holds. A status bit never rises without its enable set. Status bits fall only through a clear write, and a clear write removes every cleared bit that was not hit again. The enable register changes only on its own write. The bench scenarios show the per-class mapping that a global property cannot. Those scenarios cover which strobe lands in which status bit, the trap condition gating, the two return sources, the two unconditional sources, clear-versus-set priority within one cycle, and several events collected on one edge.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int NUM_EV = 8;
    localparam int EV_W   = $clog2(NUM_EV);

    typedef enum logic [EV_W-1:0] {
        EV_BRANCH   = 3'd0,
        EV_COMPLETE = 3'd1,
        EV_RETURN   = 3'd2,
        EV_INTR     = 3'd3,
        EV_TRAP     = 3'd4,
        EV_IADDR    = 3'd5,
        EV_DADDR    = 3'd6,
        EV_UNCOND   = 3'd7
    } ev_e;

    typedef struct packed {
        logic br_taken;
        logic instr_done;
        logic norm_ret;
        logic crit_ret;
        logic irq_taken;
        logic trap_instr;
        logic trap_cond;
        logic iaddr_match;
        logic daddr_match;
        logic tap_req;
        logic ext_req;
    } strobe_t;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    // Timing class of each event: 1 = raised before execution (holds the instruction)
    function automatic logic is_pre(input ev_e ev);
        case (ev)
            EV_BRANCH, EV_TRAP, EV_IADDR, EV_DADDR: is_pre = 1'b1;
            default:                                is_pre = 1'b0;
        endcase
    endfunction

    // Map pipeline strobes onto the event vector
    function automatic ev_vec_t strobes_to_events(input strobe_t s);
        ev_vec_t v;
        v = '0;
        v[EV_BRANCH]   = s.br_taken;
        v[EV_COMPLETE] = s.instr_done;
        v[EV_RETURN]   = s.norm_ret | s.crit_ret;
        v[EV_INTR]     = s.irq_taken;
        v[EV_TRAP]     = s.trap_instr & s.trap_cond;
        v[EV_IADDR]    = s.iaddr_match;
        v[EV_DADDR]    = s.daddr_match;
        v[EV_UNCOND]   = s.tap_req | s.ext_req;
        return v;
    endfunction

endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
    import dbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_we,
    input  logic    cfg_addr,
    input  ev_vec_t cfg_wdata,
    output ev_vec_t enable,
    output ev_vec_t clr_mask
);

    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_CLEAR  = 1'b1;

    ev_vec_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (cfg_we && cfg_addr == SEL_ENABLE) begin
            en_q <= cfg_wdata;
        end
    end

    always_comb begin
        clr_mask = '0;
        if (cfg_we && cfg_addr == SEL_CLEAR) begin
            clr_mask = cfg_wdata;
        end
    end

    assign enable = en_q;

    AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_addr == SEL_ENABLE) |=> $stable(en_q)); // R2

endmodule

// File: rtl/dbg_classify.sv
module dbg_classify
    import dbg_pkg::*;
(
    input  strobe_t strobes,
    input  ev_vec_t enable,
    output ev_vec_t hits,
    output ev_vec_t pre_hits,
    output ev_vec_t post_hits
);

    ev_vec_t raw;

    assign raw  = strobes_to_events(strobes);
    assign hits = raw & enable;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_class
        if (is_pre(ev_e'(i))) begin : g_pre
            assign pre_hits[i]  = hits[i];
            assign post_hits[i] = 1'b0;
        end else begin : g_post
            assign pre_hits[i]  = 1'b0;
            assign post_hits[i] = hits[i];
        end
    end

    always_comb begin
        AST_CLASS_DISJOINT: assert ((pre_hits & post_hits) == '0); // R6
    end

endmodule

// File: rtl/dbg_status.sv
module dbg_status
    import dbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t hits,
    input  ev_vec_t clr_mask,
    output ev_vec_t status
);

    ev_vec_t status_q;

    // New hits take priority over a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | hits;
        end
    end

    assign status = status_q;

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((status_q & $past(clr_mask) & ~$past(hits)) == '0)); // R8

    AST_HIT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (hits != '0) |=> ((status_q & $past(hits)) == $past(hits))); // R9

endmodule

// File: rtl/dbg_event_collector.sv
module dbg_event_collector
    import dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [NUM_EV-1:0] cfg_wdata,
    input  logic              br_taken,
    input  logic              instr_done,
    input  logic              norm_ret_done,
    input  logic              crit_ret_done,
    input  logic              irq_taken,
    input  logic              trap_instr,
    input  logic              trap_cond,
    input  logic              iaddr_match,
    input  logic              daddr_match,
    input  logic              tap_req,
    input  logic              ext_req,
    output logic              dbg_event,
    output logic              hold_instr,
    output logic [NUM_EV-1:0] status
);

    strobe_t strobes;
    ev_vec_t enable;
    ev_vec_t clr_mask;
    ev_vec_t hits;
    ev_vec_t pre_hits;
    ev_vec_t post_hits;
    ev_vec_t status_q;

    assign strobes = '{
        br_taken:    br_taken,
        instr_done:  instr_done,
        norm_ret:    norm_ret_done,
        crit_ret:    crit_ret_done,
        irq_taken:   irq_taken,
        trap_instr:  trap_instr,
        trap_cond:   trap_cond,
        iaddr_match: iaddr_match,
        daddr_match: daddr_match,
        tap_req:     tap_req,
        ext_req:     ext_req
    };

    dbg_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .enable    (enable),
        .clr_mask  (clr_mask)
    );

    dbg_classify u_class (
        .strobes   (strobes),
        .enable    (enable),
        .hits      (hits),
        .pre_hits  (pre_hits),
        .post_hits (post_hits)
    );

    dbg_status u_status (
        .clk      (clk),
        .rst      (rst),
        .hits     (hits),
        .clr_mask (clr_mask),
        .status   (status_q)
    );

    assign dbg_event  = (pre_hits | post_hits) != '0;
    assign hold_instr = pre_hits != '0;
    assign status     = status_q;

    AST_HOLD_IMPLIES_EVENT: assert property (@(posedge clk) disable iff (rst)
        hold_instr |-> dbg_event); // R5

    AST_POST_NEVER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (post_hits != '0 && pre_hits == '0) |-> !hold_instr); // R6

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((~enable & ~status_q) != '0) |=>
            ((status_q & ~$past(status_q) & ~$past(enable)) == '0)); // R3

    AST_EVENT_RECORDED: assert property (@(posedge clk) disable iff (rst)
        dbg_event |=> (status_q != '0)); // R4

endmodule

// File: tb/test_dbg_event_collector.sv
module test_dbg_event_collector;
    import dbg_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    // strobe vector bit positions for the drive task
    localparam int S_BR = 10, S_DONE = 9, S_NRET = 8, S_CRET = 7, S_IRQ = 6,
                   S_TRI = 5, S_TRC = 4, S_IA = 3, S_DA = 2, S_TAP = 1, S_EXT = 0;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we, cfg_addr;
    logic [NUM_EV-1:0] cfg_wdata;
    logic br_taken, instr_done, norm_ret_done, crit_ret_done, irq_taken;
    logic trap_instr, trap_cond, iaddr_match, daddr_match, tap_req, ext_req;
    logic dbg_event, hold_instr;
    logic [NUM_EV-1:0] status;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_event_collector i_dbg_event_collector (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .br_taken(br_taken), .instr_done(instr_done), .norm_ret_done(norm_ret_done),
        .crit_ret_done(crit_ret_done), .irq_taken(irq_taken), .trap_instr(trap_instr),
        .trap_cond(trap_cond), .iaddr_match(iaddr_match), .daddr_match(daddr_match),
        .tap_req(tap_req), .ext_req(ext_req), .dbg_event(dbg_event),
        .hold_instr(hold_instr), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_strobes(input logic [10:0] v);
        br_taken = v[S_BR];     instr_done = v[S_DONE];
        norm_ret_done = v[S_NRET]; crit_ret_done = v[S_CRET];
        irq_taken = v[S_IRQ];   trap_instr = v[S_TRI];  trap_cond = v[S_TRC];
        iaddr_match = v[S_IA];  daddr_match = v[S_DA];
        tap_req = v[S_TAP];     ext_req = v[S_EXT];
    endtask

    task automatic cfg_write(input logic addr, input logic [NUM_EV-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    // One-cycle strobe: check combinational outputs, then status after the edge
    task automatic pulse(input string req, input logic [10:0] v, input logic exp_ev,
                         input logic exp_hold, input logic [NUM_EV-1:0] exp_status);
        @(negedge clk);
        set_strobes(v);
        #1;
        chk({req, " event"}, 32'(dbg_event), 32'(exp_ev));
        chk({req, " hold"}, 32'(hold_instr), 32'(exp_hold));
        @(negedge clk);
        set_strobes('0);
        #1;
        chk({req, " status"}, 32'(status), 32'(exp_status));
    endtask

    task automatic clear_all();
        cfg_write(1'b1, '1);
    endtask

    task automatic t_reset();
        chk("R1 status", 32'(status), 0);
        chk("R1 event", 32'(dbg_event), 0);
        chk("R1 hold", 32'(hold_instr), 0);
        pulse("R1 enables zero", 11'h7FF, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_disabled();
        cfg_write(1'b0, 8'h02);
        pulse("R3 branch disabled", 11'(1 << S_BR), 1'b0, 1'b0, 8'h00);
        pulse("R3 trap disabled", 11'((1 << S_TRI) | (1 << S_TRC)), 1'b0, 1'b0, 8'h00);
        pulse("R2 completion enabled", 11'(1 << S_DONE), 1'b1, 1'b0, 8'h02);
        clear_all();
    endtask

    task automatic t_pre();
        cfg_write(1'b0, 8'hFF);
        pulse("R5 branch", 11'(1 << S_BR), 1'b1, 1'b1, 8'h01);
        pulse("R5 iaddr", 11'(1 << S_IA), 1'b1, 1'b1, 8'h21);
        pulse("R5 daddr", 11'(1 << S_DA), 1'b1, 1'b1, 8'h61);
        clear_all();
        chk("R8 clear all", 32'(status), 0);
    endtask

    task automatic t_post();
        pulse("R6 completion", 11'(1 << S_DONE), 1'b1, 1'b0, 8'h02);
        pulse("R6 interrupt", 11'(1 << S_IRQ), 1'b1, 1'b0, 8'h0A);
        clear_all();
    endtask

    task automatic t_trap();
        pulse("R11 trap no cond", 11'(1 << S_TRI), 1'b0, 1'b0, 8'h00);
        pulse("R11 cond no trap", 11'(1 << S_TRC), 1'b0, 1'b0, 8'h00);
        pulse("R11 trap taken", 11'((1 << S_TRI) | (1 << S_TRC)), 1'b1, 1'b1, 8'h10);
        clear_all();
    endtask

    task automatic t_return();
        pulse("R12 normal return", 11'(1 << S_NRET), 1'b1, 1'b0, 8'h04);
        clear_all();
        pulse("R12 critical return", 11'(1 << S_CRET), 1'b1, 1'b0, 8'h04);
        clear_all();
    endtask

    task automatic t_uncond();
        pulse("R10 tap request", 11'(1 << S_TAP), 1'b1, 1'b0, 8'h80);
        clear_all();
        pulse("R10 external request", 11'(1 << S_EXT), 1'b1, 1'b0, 8'h80);
        clear_all();
    endtask

    task automatic t_multi();
        pulse("R9 three at once", 11'((1 << S_BR) | (1 << S_DONE) | (1 << S_IRQ)),
              1'b1, 1'b1, 8'h0B);
        repeat (3) @(negedge clk);
        chk("R7 sticky", 32'(status), 32'h0B);
    endtask

    task automatic t_clear();
        cfg_write(1'b1, 8'h02);
        chk("R8 partial clear", 32'(status), 32'h09);
        @(negedge clk);
        set_strobes(11'(1 << S_BR));
        cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h09;
        @(negedge clk);
        set_strobes('0);
        cfg_we = 1'b0; cfg_wdata = '0;
        #1;
        chk("R8 set beats clear", 32'(status), 32'h01);
        clear_all();
    endtask

    task automatic t_enable_change();
        cfg_write(1'b0, 8'h10);
        pulse("R2 branch now off", 11'(1 << S_BR), 1'b0, 1'b0, 8'h00);
        pulse("R4 trap still on", 11'((1 << S_TRI) | (1 << S_TRC)), 1'b1, 1'b1, 8'h10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
        set_strobes('0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_disabled();
        t_pre();
        t_post();
        t_trap();
        t_return();
        t_uncond();
        t_multi();
        t_clear();
        t_enable_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule